// File: doc/BRIEF.md
# Partial Egress Timestamp Capture and Rebuild

This block keeps a truncated egress timestamp for each port of a switch. When a port reports that a frame has left, the block copies the low `TS_BITS` bits of the running time counter into that port's slot and marks the slot as fresh. A host-side read port returns the slot as a packed word. The word carries the timestamp in its top bits and the fresh flag in bit 0. Reading a slot clears its flag. A capture that arrives before the slot has been read overwrites the stored value.

A separate rebuild datapath turns a partial timestamp back into a full 64-bit time value. It takes the current full clock value and a partial timestamp. It keeps the clock's bits above `TS_BITS` and places the partial value below them. If the clock's own low bits are not greater than the partial value, the counter has wrapped since the capture, so one wrap period (2^TS_BITS) is subtracted. The result is only meaningful when the rebuild happens within one wrap period of the capture. At an 8 ns tick that is about 0.134 s for 24 bits and about 34.4 s for 32 bits.

Each port slot is a two-state machine, built from `SLOT_EMPTY` and `SLOT_FRESH`:
- The capture transition goes from either state to `SLOT_FRESH`.
- The clear transition goes from `SLOT_FRESH` to `SLOT_EMPTY`. It is taken on a read of that slot with no capture at the same edge.
- With no event, a slot holds its state.

The read port and the rebuild stage each run a two-state machine, built from `STAGE_IDLE` and `STAGE_OUT`:
- The launch transition goes to `STAGE_OUT` on a request (`rd_en` or `rb_valid_in`).
- The retire transition goes back to `STAGE_IDLE` when no request follows.
- The valid output is high only in `STAGE_OUT`.

Top module: `ptstamp_unit`

## Requirements
- R1: After reset, every slot is empty. `rd_valid` and `rb_valid_out` are low. A read of any port returns an all-zero word.
- R2: When `frame_sent[p]` is high at a clock edge, slot p stores `cnt_low` from that edge and becomes fresh. A later read of p returns flag bit 0 = 1 and that timestamp.
- R3: Word layout depends on `TS_BITS`. For 24, the word is 32 bits: timestamp in bits 31:8, fresh flag in bit 0, bits 7:1 zero. For 32, the word is 64 bits: timestamp in bits 63:32, fresh flag in bit 0, bits 31:1 zero.
- R4: A read request (`rd_en` with `rd_port`) at one edge gives `rd_valid` high and the word on `rd_word` after that edge, one cycle of latency. `rd_valid` is low in cycles after no request.
- R5: A read returns the slot as it stood before the edge, then clears the slot's flag and keeps the timestamp. If a capture on the same port coincides with the read, the read returns the old contents and the slot stays fresh with the new timestamp.
- R6: A second capture on a fresh, unread slot replaces the stored timestamp. The flag stays set.
- R7: A capture or read on one port leaves every other port's slot unchanged.
- R8: The rebuilt value equals {`rb_now`[63:TS_BITS], `rb_partial`}. When `rb_now`[TS_BITS-1:0] <= `rb_partial`, 2^TS_BITS is subtracted from it, modulo 2^64.
- R9: The rebuilt value appears on `rb_full` one cycle after `rb_valid_in`, with `rb_valid_out` high in that cycle only. `rb_full` holds its value while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_low | input | TS_BITS | Low bits of the running time counter |
| frame_sent | input | NUM_PORTS | Per-port frame-departure pulse |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port selected for the read |
| rd_valid | output | 1 | Read word valid |
| rd_word | output | WORD_W | Packed timestamp word (32 or 64 bits) |
| rb_valid_in | input | 1 | Rebuild request |
| rb_partial | input | TS_BITS | Partial timestamp to rebuild |
| rb_now | input | 64 | Current full clock value |
| rb_valid_out | output | 1 | Rebuilt value valid |
| rb_full | output | 64 | Rebuilt 64-bit timestamp |

## Verification
The distance assertion assumes the high part of `rb_now` is not zero. Only with a non-zero high part does the rebuilt value lie below the clock value and within one wrap period of it, so the assertion is gated on that condition. The bench still drives a zero high part to cover the modulo-2^64 underflow case, and checks that case only arithmetically. The flag assertions assume `rd_port` names an existing port; the bench drives only port numbers below `NUM_PORTS`. The rebuild sweep crosses partial values at both ends and the middle of the range with counter low bits just below, equal to and just above each partial value.

// File: rtl/ptstamp_pkg.sv
package ptstamp_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FRESH = 1'b1
    } slot_state_e;

    typedef enum logic {
        STAGE_IDLE = 1'b0,
        STAGE_OUT  = 1'b1
    } stage_state_e;

    // Width of the packed host word for a given partial-timestamp width
    function automatic int word_width(input int ts_bits);
        return (ts_bits <= 24) ? 32 : 64;
    endfunction

endpackage

// File: rtl/ptstamp_slot.sv
module ptstamp_slot
    import ptstamp_pkg::*;
#(
    parameter int TS_BITS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic               clr,
    input  logic [TS_BITS-1:0] cnt_low,
    output logic               fresh,
    output logic [TS_BITS-1:0] ts
);

    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            ts      <= '0;
        end else begin
            state_q <= state_d;
            if (cap) ts <= cnt_low;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (cap) state_d = SLOT_FRESH;
            SLOT_FRESH: if (!cap && clr) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        fresh = (state_q == SLOT_FRESH);
    end

endmodule

// File: rtl/ptstamp_read.sv
module ptstamp_read
    import ptstamp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int TS_BITS   = 24,
    parameter int WORD_W    = 32,
    parameter int PORT_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_en,
    input  logic [PORT_W-1:0]                rd_port,
    input  logic [NUM_PORTS-1:0]             fresh_vec,
    input  logic [NUM_PORTS-1:0][TS_BITS-1:0] ts_vec,
    output logic [NUM_PORTS-1:0]             clr_vec,
    output logic                             rd_valid,
    output logic [WORD_W-1:0]                rd_word
);

    localparam int PAD_W = WORD_W - TS_BITS - 1;

    stage_state_e state_q, state_d;
    logic [WORD_W-1:0] word_d;
    logic              sel_fresh;
    logic [TS_BITS-1:0] sel_ts;

    // Per-port clear strobes
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_clr
        assign clr_vec[i] = rd_en && (rd_port == PORT_W'(i));
    end

    always_comb begin
        sel_fresh = 1'b0;
        sel_ts    = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (clr_vec[i]) begin
                sel_fresh = fresh_vec[i];
                sel_ts    = ts_vec[i];
            end
        end
        word_d = {sel_ts, {PAD_W{1'b0}}, sel_fresh};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STAGE_IDLE;
            rd_word <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) rd_word <= word_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STAGE_IDLE: if (rd_en)  state_d = STAGE_OUT;
            STAGE_OUT:  if (!rd_en) state_d = STAGE_IDLE;
            default:    state_d = STAGE_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = (state_q == STAGE_OUT);
    end

endmodule

// File: rtl/ptstamp_rebuild.sv
module ptstamp_rebuild
    import ptstamp_pkg::*;
#(
    parameter int TS_BITS = 24,
    parameter int CLK_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [TS_BITS-1:0] partial,
    input  logic [CLK_W-1:0]   now,
    output logic               valid_out,
    output logic [CLK_W-1:0]   full
);

    localparam logic [CLK_W-1:0] WRAP = CLK_W'(1) << TS_BITS;

    stage_state_e state_q, state_d;
    logic [CLK_W-1:0] spliced;
    logic             wrapped;
    logic [CLK_W-1:0] full_d;

    always_comb begin
        spliced = {now[CLK_W-1:TS_BITS], partial};
        wrapped = (now[TS_BITS-1:0] <= partial);
        full_d  = wrapped ? (spliced - WRAP) : spliced;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STAGE_IDLE;
            full    <= '0;
        end else begin
            state_q <= state_d;
            if (valid_in) full <= full_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STAGE_IDLE: if (valid_in)  state_d = STAGE_OUT;
            STAGE_OUT:  if (!valid_in) state_d = STAGE_IDLE;
            default:    state_d = STAGE_IDLE;
        endcase
    end

    always_comb begin
        valid_out = (state_q == STAGE_OUT);
    end

endmodule

// File: rtl/ptstamp_unit.sv
module ptstamp_unit
    import ptstamp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int TS_BITS   = 24,
    localparam int WORD_W   = word_width(TS_BITS),
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TS_BITS-1:0]   cnt_low,
    input  logic [NUM_PORTS-1:0] frame_sent,
    input  logic                 rd_en,
    input  logic [PORT_W-1:0]    rd_port,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_word,
    input  logic                 rb_valid_in,
    input  logic [TS_BITS-1:0]   rb_partial,
    input  logic [63:0]          rb_now,
    output logic                 rb_valid_out,
    output logic [63:0]          rb_full
);

    logic [NUM_PORTS-1:0]              fresh_vec;
    logic [NUM_PORTS-1:0]              clr_vec;
    logic [NUM_PORTS-1:0][TS_BITS-1:0] ts_vec;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
        ptstamp_slot #(.TS_BITS(TS_BITS)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (frame_sent[p]),
            .clr     (clr_vec[p]),
            .cnt_low (cnt_low),
            .fresh   (fresh_vec[p]),
            .ts      (ts_vec[p])
        );
    end

    ptstamp_read #(
        .NUM_PORTS (NUM_PORTS),
        .TS_BITS   (TS_BITS),
        .WORD_W    (WORD_W),
        .PORT_W    (PORT_W)
    ) read_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_port   (rd_port),
        .fresh_vec (fresh_vec),
        .ts_vec    (ts_vec),
        .clr_vec   (clr_vec),
        .rd_valid  (rd_valid),
        .rd_word   (rd_word)
    );

    ptstamp_rebuild #(
        .TS_BITS (TS_BITS),
        .CLK_W   (64)
    ) rebuild_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (rb_valid_in),
        .partial   (rb_partial),
        .now       (rb_now),
        .valid_out (rb_valid_out),
        .full      (rb_full)
    );

endmodule

// File: rtl/ptstamp_unit_chk.sv
module ptstamp_unit_chk #(
    parameter int NUM_PORTS = 4,
    parameter int TS_BITS   = 24,
    parameter int WORD_W    = 32,
    parameter int PORT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] frame_sent,
    input logic                 rd_en,
    input logic [PORT_W-1:0]    rd_port,
    input logic                 rd_valid,
    input logic [WORD_W-1:0]    rd_word,
    input logic                 rb_valid_in,
    input logic [TS_BITS-1:0]   rb_partial,
    input logic [63:0]          rb_now,
    input logic                 rb_valid_out,
    input logic [63:0]          rb_full
);

    localparam logic [63:0] WRAP = 64'(1) << TS_BITS;

    logic [NUM_PORTS-1:0] sent_q;
    always_ff @(posedge clk) begin
        if (!rst_n) sent_q <= '0;
        else        sent_q <= frame_sent;
    end

    // R4
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R4
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    capture_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sent_q[rd_port]) |=> rd_word[0]);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && (rd_port == $past(rd_port)) && !sent_q[rd_port])
        |=> !rd_word[0]);

    // R9
    rebuild_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid_in |=> (rb_valid_out && (rb_full[TS_BITS-1:0] == $past(rb_partial))));

    // R9
    rebuild_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_valid_in |=> (!rb_valid_out && $stable(rb_full)));

    // R8
    rebuild_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_valid_in && (rb_now[63:TS_BITS] != '0))
        |=> (($past(rb_now) > rb_full) && (($past(rb_now) - rb_full) <= WRAP)));

endmodule

bind ptstamp_unit ptstamp_unit_chk #(
    .NUM_PORTS (NUM_PORTS),
    .TS_BITS   (TS_BITS),
    .WORD_W    (WORD_W),
    .PORT_W    (PORT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sent   (frame_sent),
    .rd_en        (rd_en),
    .rd_port      (rd_port),
    .rd_valid     (rd_valid),
    .rd_word      (rd_word),
    .rb_valid_in  (rb_valid_in),
    .rb_partial   (rb_partial),
    .rb_now       (rb_now),
    .rb_valid_out (rb_valid_out),
    .rb_full      (rb_full)
);

// File: tb/ptstamp_unit_tb_top.sv
module ptstamp_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int N  = 24;
    localparam int W  = 32;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cnt_low = '0;
    logic [P-1:0]  frame_sent = '0;
    logic          rd_en = 1'b0;
    logic [PW-1:0] rd_port = '0;
    logic          rd_valid;
    logic [W-1:0]  rd_word;
    logic          rb_valid_in = 1'b0;
    logic [N-1:0]  rb_partial = '0;
    logic [63:0]   rb_now = '0;
    logic          rb_valid_out;
    logic [63:0]   rb_full;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptstamp_unit #(.NUM_PORTS(P), .TS_BITS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_low(cnt_low), .frame_sent(frame_sent),
        .rd_en(rd_en), .rd_port(rd_port), .rd_valid(rd_valid), .rd_word(rd_word),
        .rb_valid_in(rb_valid_in), .rb_partial(rb_partial), .rb_now(rb_now),
        .rb_valid_out(rb_valid_out), .rb_full(rb_full)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3 layout: timestamp in bits 31:8, flag in bit 0
    function automatic logic [W-1:0] exp_word(input logic [N-1:0] ts, input bit flag);
        return (W'(ts) << (W - N)) | W'(flag);
    endfunction

    function automatic logic [63:0] exp_full(input logic [63:0] now, input logic [N-1:0] part);
        logic [63:0] base;
        base = ((now >> N) << N) | 64'(part);
        if (now[N-1:0] <= part) base = base - (64'(1) << N);
        return base;
    endfunction

    task automatic capture(input int p, input logic [N-1:0] t);
        @(negedge clk);
        cnt_low = t;
        frame_sent = P'(1) << p;
        @(negedge clk);
        frame_sent = '0;
    endtask

    task automatic read_port(input int p, output logic [W-1:0] w);
        @(negedge clk);
        rd_en = 1'b1;
        rd_port = PW'(p);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, "R4 rd_valid after request", 64'(rd_valid), 64'd1);
        w = rd_word;
    endtask

    task automatic rebuild(input logic [63:0] now, input logic [N-1:0] part);
        logic [63:0] e;
        @(negedge clk);
        rb_valid_in = 1'b1;
        rb_now = now;
        rb_partial = part;
        e = exp_full(now, part);
        @(negedge clk);
        rb_valid_in = 1'b0;
        check(rb_valid_out === 1'b1, "R9 rb_valid_out", 64'(rb_valid_out), 64'd1);
        check(rb_full === e, "R8 rebuilt value", rb_full, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        logic [63:0] held;
        logic [N-1:0] parts [5];
        logic [63:0] highs [3];
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_valid === 1'b0, "R1 rd_valid in reset", 64'(rd_valid), 0);
        check(rb_valid_out === 1'b0, "R1 rb_valid_out in reset", 64'(rb_valid_out), 0);
        rst_n = 1'b1;
        for (int p = 0; p < P; p++) begin
            read_port(p, w);
            check(w === '0, "R1 empty slot after reset", 64'(w), 0);
        end
        @(negedge clk);
        check(rd_valid === 1'b0, "R4 rd_valid idle", 64'(rd_valid), 0);

        // R2 / R3 / R5 per port, several counter values
        for (int p = 0; p < P; p++) begin
            for (int k = 0; k < 3; k++) begin
                logic [N-1:0] t;
                t = (k == 0) ? N'(0) : (k == 1) ? '1 : N'(24'h5A3C00 + p * 24'h010101);
                capture(p, t);
                read_port(p, w);
                check(w === exp_word(t, 1), "R2 R3 captured word", 64'(w), 64'(exp_word(t, 1)));
                read_port(p, w);
                check(w === exp_word(t, 0), "R5 flag cleared, ts kept", 64'(w), 64'(exp_word(t, 0)));
            end
        end

        // R7 isolation: capture port 2 only, others keep cleared contents
        capture(2, 24'hABCDEF);
        for (int p = 0; p < P; p++) begin
            read_port(p, w);
            if (p == 2)
                check(w === exp_word(24'hABCDEF, 1), "R7 target port", 64'(w), 64'(exp_word(24'hABCDEF, 1)));
            else
                check(w[0] === 1'b0, "R7 other port untouched", 64'(w[0]), 0);
        end

        // R6 overwrite of unread capture
        capture(1, 24'h111111);
        capture(1, 24'h222222);
        read_port(1, w);
        check(w === exp_word(24'h222222, 1), "R6 overwrite", 64'(w), 64'(exp_word(24'h222222, 1)));

        // R5 read coinciding with capture on same port
        capture(3, 24'h0000AA);
        @(negedge clk);
        cnt_low = 24'h0000BB;
        frame_sent = 4'b1000;
        rd_en = 1'b1;
        rd_port = 2'd3;
        @(negedge clk);
        frame_sent = '0;
        rd_en = 1'b0;
        check(rd_word === exp_word(24'h0000AA, 1), "R5 coincident read returns old",
              64'(rd_word), 64'(exp_word(24'h0000AA, 1)));
        read_port(3, w);
        check(w === exp_word(24'h0000BB, 1), "R5 coincident capture stays fresh",
              64'(w), 64'(exp_word(24'h0000BB, 1)));

        // R8 sweep
        parts[0] = '0; parts[1] = N'(1); parts[2] = N'(1) << (N - 1);
        parts[3] = '1 - N'(1); parts[4] = '1;
        highs[0] = 64'd0; highs[1] = 64'd1; highs[2] = 64'h12_3456_789A;
        for (int h = 0; h < 3; h++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [N-1:0] lo;
                    case (j)
                        0: lo = '0;
                        1: lo = N'(1);
                        2: lo = parts[i] - N'(1);
                        3: lo = parts[i];
                        4: lo = parts[i] + N'(1);
                        default: lo = '1;
                    endcase
                    rebuild((highs[h] << N) | 64'(lo), parts[i]);
                end
            end
        end

        // R9 hold when idle
        held = rb_full;
        rb_now = 64'hFFFF_0000_1234_5678;
        rb_partial = 24'h777777;
        @(negedge clk);
        check(rb_valid_out === 1'b0, "R9 valid_out low when idle", 64'(rb_valid_out), 0);
        check(rb_full === held, "R9 result held", rb_full, held);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule